// File: doc/BRIEF.md
# RV32IM Execute-Stage ALU with Function Decode

This block is the arithmetic heart of the execute stage in a 32-bit integer core that also implements the multiply/divide extension. It takes the opcode, funct3 and funct7 fields of the instruction in execute, together with two 32-bit operands that upstream logic has already chosen from a register, an immediate or the program counter. From these it produces a 5-bit internal function code and a 32-bit result. The block is purely combinational: the decode and the result are both valid in the same cycle as the inputs, and this includes every multiply, divide and remainder operation.

For register-register instructions the decode looks at funct7 first. The value 0000001 selects the multiply/divide family, and only after that choice is funct3 used to pick the operation. Any instruction that only needs an address or a link value is decoded to a plain add: upper-immediate forms, loads, stores, branch targets and jumps. Operand selection, branch comparison, the jump decision, memory access and the register file all sit outside this block.

Top module: `rv_exec_alu`

## Requirements
- R1: Opcodes 0110111 (LUI), 0010111 (AUIPC), 0000011 (load), 0100011 (store), 1100011 (branch), 1101111 (JAL) and 1100111 (JALR) give function code ADD. Every opcode not named in R1, R3, R4 or R5 also gives ADD.
- R2: The function codes on alu_fn are: ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9, MUL=10, MULH=11, MULHSU=12, MULHU=13, DIV=14, DIVU=15, REM=16, REMU=17.
- R3: For opcode 0110011 with funct7 other than 0000001, funct3 selects the operation. funct3=0 gives ADD, or SUB when funct7 bit 5 is set. The other values are 1 SLL, 2 SLT, 3 SLTU, 4 XOR, 6 OR and 7 AND. funct3=5 gives SRL, or SRA when funct7 bit 5 is set.
- R4: For opcode 0110011 with funct7 equal to 0000001, funct3 values 0 to 7 select MUL, MULH, MULHSU, MULHU, DIV, DIVU, REM and REMU in that order.
- R5: For opcode 0010011, funct3 uses the same mapping as R3, with two differences. funct3=0 always gives ADD, whatever funct7 holds. funct7 bit 5 matters only at funct3=5, where it selects SRA.
- R6: Shift amounts are op2[4:0]. SLT compares signed and SLTU compares unsigned, and both return 1 or 0. ADD, SUB, XOR, OR and AND are the usual 32-bit operations, with wraparound.
- R7: MUL returns the low 32 bits of op1*op2. MULH returns the high 32 bits of the signed×signed 64-bit product, MULHSU the high 32 bits of signed op1 × unsigned op2, and MULHU the high 32 bits of the unsigned×unsigned product.
- R8: DIV and DIVU round the quotient toward zero. REM and REMU return a remainder that carries the sign of the dividend (signed form) or is unsigned.
- R9: When op2 is zero, DIV and DIVU return 0xFFFFFFFF, and REM and REMU return op1.
- R10: For op1=0x80000000 and op2=0xFFFFFFFF, DIV returns 0x80000000 and REM returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Instruction opcode field |
| funct3 | input | 3 | Instruction funct3 field |
| funct7 | input | 7 | Instruction funct7 field |
| op1 | input | 32 | First operand, already selected |
| op2 | input | 32 | Second operand, already selected |
| alu_fn | output | 5 | Decoded function code (R2) |
| result | output | 32 | Operation result |

## Verification
The case where two functions fall in the same cycle is a divide-family special case meeting another one: a zero divisor together with a most-negative dividend, or the signed-overflow pair. In that case the zero-divisor rule and the overflow rule compete with the ordinary quotient. The bench provokes this by aiming directed vectors at those operand pairs and by biasing the random operands toward 0, -1 and 0x80000000. It judges each result against a reference that computes in 64-bit signed arithmetic, where the special values come out of plain rules and not out of a copied priority mux. The second case is the funct7 split. A register-register instruction whose funct7 is 0000001 must follow the multiply/divide decode, even at funct3 positions where bit 5 would matter for the standard group. The bench checks this on the function code itself.

// File: rtl/rv_exec_alu.sv
module rv_exec_alu (
  input  logic [6:0]  opcode,
  input  logic [2:0]  funct3,
  input  logic [6:0]  funct7,
  input  logic [31:0] op1,
  input  logic [31:0] op2,
  output logic [4:0]  alu_fn,
  output logic [31:0] result
);
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] F7_MD   = 7'b0000001;

  localparam logic [4:0] FN_ADD = 5'd0,  FN_SUB = 5'd1,  FN_SLL = 5'd2,  FN_SLT = 5'd3;
  localparam logic [4:0] FN_SLTU = 5'd4, FN_XOR = 5'd5,  FN_SRL = 5'd6,  FN_SRA = 5'd7;
  localparam logic [4:0] FN_OR = 5'd8,   FN_AND = 5'd9,  FN_MUL = 5'd10, FN_MULH = 5'd11;
  localparam logic [4:0] FN_MULHSU = 5'd12, FN_MULHU = 5'd13, FN_DIV = 5'd14, FN_DIVU = 5'd15;
  localparam logic [4:0] FN_REM = 5'd16, FN_REMU = 5'd17;

  logic is_reg, is_imm, alt;
  assign is_reg = (opcode == OPC_REG);
  assign is_imm = (opcode == OPC_IMM);
  assign alt    = funct7[5];

  always_comb begin
    alu_fn = FN_ADD;
    if (is_reg && funct7 == F7_MD) begin
      alu_fn = FN_MUL + {2'b00, funct3};
    end else if (is_reg || is_imm) begin
      case (funct3)
        3'd0:    alu_fn = (is_reg && alt) ? FN_SUB : FN_ADD;
        3'd1:    alu_fn = FN_SLL;
        3'd2:    alu_fn = FN_SLT;
        3'd3:    alu_fn = FN_SLTU;
        3'd4:    alu_fn = FN_XOR;
        3'd5:    alu_fn = alt ? FN_SRA : FN_SRL;
        3'd6:    alu_fn = FN_OR;
        default: alu_fn = FN_AND;
      endcase
    end
  end

  logic [4:0]  shamt;
  logic [63:0] sx1, sx2, zx1, zx2;
  logic [63:0] prod_ss, prod_su, prod_uu;
  assign shamt   = op2[4:0];
  assign sx1     = {{32{op1[31]}}, op1};
  assign sx2     = {{32{op2[31]}}, op2};
  assign zx1     = {32'b0, op1};
  assign zx2     = {32'b0, op2};
  assign prod_ss = sx1 * sx2;
  assign prod_su = sx1 * zx2;
  assign prod_uu = zx1 * zx2;

  logic by_zero, ovf;
  logic [31:0] q_s, r_s, q_u, r_u;
  assign by_zero = (op2 == 32'd0);
  assign ovf     = (op1 == 32'h8000_0000) && (op2 == 32'hFFFF_FFFF);

  always_comb begin
    q_s = 32'hFFFF_FFFF;
    r_s = op1;
    q_u = 32'hFFFF_FFFF;
    r_u = op1;
    if (!by_zero) begin
      q_u = op1 / op2;
      r_u = op1 % op2;
      if (ovf) begin
        q_s = 32'h8000_0000;
        r_s = 32'd0;
      end else begin
        q_s = $signed(op1) / $signed(op2);
        r_s = $signed(op1) % $signed(op2);
      end
    end
  end

  always_comb begin
    case (alu_fn)
      FN_SUB:    result = op1 - op2;
      FN_SLL:    result = op1 << shamt;
      FN_SLT:    result = {31'b0, $signed(op1) < $signed(op2)};
      FN_SLTU:   result = {31'b0, op1 < op2};
      FN_XOR:    result = op1 ^ op2;
      FN_SRL:    result = op1 >> shamt;
      FN_SRA:    result = $signed(op1) >>> shamt;
      FN_OR:     result = op1 | op2;
      FN_AND:    result = op1 & op2;
      FN_MUL:    result = prod_uu[31:0];
      FN_MULH:   result = prod_ss[63:32];
      FN_MULHSU: result = prod_su[63:32];
      FN_MULHU:  result = prod_uu[63:32];
      FN_DIV:    result = q_s;
      FN_DIVU:   result = q_u;
      FN_REM:    result = r_s;
      FN_REMU:   result = r_u;
      default:   result = op1 + op2;
    endcase
  end
endmodule

module rv_exec_alu_chk (
  input logic [6:0]  opcode,
  input logic [2:0]  funct3,
  input logic [6:0]  funct7,
  input logic [31:0] op1,
  input logic [31:0] op2,
  input logic [4:0]  alu_fn,
  input logic [31:0] result
);
  logic known;
  assign known = !$isunknown({opcode, funct3, funct7, op1, op2, alu_fn, result});

  always_comb begin
    if (known) begin
      a_r1_lui_add: assert (opcode != 7'b0110111 || alu_fn == 5'd0);
      a_r2_fn_range: assert (alu_fn <= 5'd17);
      a_r4_md_group: assert (!(opcode == 7'b0110011 && funct7 == 7'b0000001) || (alu_fn >= 5'd10 && alu_fn <= 5'd17));
      a_r5_imm_no_sub: assert (!(opcode == 7'b0010011 && funct3 == 3'd0) || alu_fn == 5'd0);
      a_r9_div_zero: assert (!((alu_fn == 5'd14 || alu_fn == 5'd15) && op2 == 32'd0) || result == 32'hFFFF_FFFF);
      a_r9_rem_zero: assert (!((alu_fn == 5'd16 || alu_fn == 5'd17) && op2 == 32'd0) || result == op1);
      a_r10_div_ovf: assert (!(alu_fn == 5'd14 && op1 == 32'h8000_0000 && op2 == 32'hFFFF_FFFF) || result == 32'h8000_0000);
      a_r10_rem_ovf: assert (!(alu_fn == 5'd16 && op1 == 32'h8000_0000 && op2 == 32'hFFFF_FFFF) || result == 32'd0);
    end
  end
endmodule

bind rv_exec_alu rv_exec_alu_chk u_chk (
  .opcode(opcode), .funct3(funct3), .funct7(funct7),
  .op1(op1), .op2(op2), .alu_fn(alu_fn), .result(result)
);

// File: tb/tb_rv_exec_alu.sv
module tb_rv_exec_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [31:0] op1 = '0, op2 = '0;
  logic [4:0]  alu_fn;
  logic [31:0] result;

  rv_exec_alu dut (.opcode(opcode), .funct3(funct3), .funct7(funct7),
                   .op1(op1), .op2(op2), .alu_fn(alu_fn), .result(result));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [4:0] ref_fn(logic [6:0] opc, logic [2:0] f3, logic [6:0] f7);
    if (opc == 7'b0110011 && f7 == 7'b0000001) return 5'd10 + 5'(f3);
    if (opc == 7'b0110011 || opc == 7'b0010011) begin
      if (f3 == 3'd0) return (opc == 7'b0110011 && f7[5]) ? 5'd1 : 5'd0;
      if (f3 == 3'd5) return f7[5] ? 5'd7 : 5'd6;
      if (f3 == 3'd1) return 5'd2;
      if (f3 == 3'd2) return 5'd3;
      if (f3 == 3'd3) return 5'd4;
      if (f3 == 3'd4) return 5'd5;
      if (f3 == 3'd6) return 5'd8;
      return 5'd9;
    end
    return 5'd0;
  endfunction

  function automatic logic [31:0] ref_res(logic [4:0] fn, logic [31:0] a, logic [31:0] b);
    longint sa, sb, ua, ub, t;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
    case (fn)
      5'd0:  t = sa + sb;
      5'd1:  t = sa - sb;
      5'd2:  t = ua * (64'd1 << b[4:0]);
      5'd3:  t = (sa < sb) ? 1 : 0;
      5'd4:  t = (ua < ub) ? 1 : 0;
      5'd5:  t = ua ^ ub;
      5'd6:  t = ua / (64'd1 << b[4:0]);
      5'd7:  t = sa >>> b[4:0];
      5'd8:  t = ua | ub;
      5'd9:  t = ua & ub;
      5'd10: t = sa * sb;
      5'd11: t = (sa * sb) >>> 32;
      5'd12: t = (sa * ub) >>> 32;
      5'd13: t = longint'((64'(ua) * 64'(ub)) >> 32);
      5'd14: t = (b == 0) ? -1 : sa / sb;
      5'd15: t = (b == 0) ? -1 : ua / ub;
      5'd16: t = (b == 0) ? sa : sa % sb;
      5'd17: t = (b == 0) ? ua : ua % ub;
      default: t = 0;
    endcase
    return t[31:0];
  endfunction

  task automatic apply(input logic [6:0] opc, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [31:0] a, input logic [31:0] b, input string req);
    logic [4:0] efn;
    logic [31:0] eres;
    @(negedge clk);
    opcode = opc; funct3 = f3; funct7 = f7; op1 = a; op2 = b;
    efn = ref_fn(opc, f3, f7);
    eres = ref_res(efn, a, b);
    #2;
    n_chk++;
    if (alu_fn !== efn || result !== eres) begin
      n_bad++;
      $display("FAIL %s: opc=%b f3=%0d f7=%b a=%h b=%h fn=%0d exp %0d result=%h exp %h",
               req, opc, f3, f7, a, b, alu_fn, efn, result, eres);
    end
  endtask

  function automatic logic [31:0] pick_op();
    case ($urandom % 8)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'd1;
      4: return 32'($urandom % 64);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] opcs [9];
    opcs = '{7'b0110111, 7'b0010111, 7'b0000011, 7'b0100011, 7'b1100011,
             7'b1101111, 7'b1100111, 7'b0110011, 7'b0010011};
    void'($urandom(32'h5EED_0071));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Reset state: zero inputs give ADD with result 0 (R1, R2)
    apply(7'd0, 3'd0, 7'd0, 32'd0, 32'd0, "R1 reset");
    // R1: address/link opcodes and an unlisted opcode all decode to ADD
    foreach (opcs[i]) if (i < 7) apply(opcs[i], 3'($urandom), 7'($urandom), 32'h1000, 32'h24, "R1");
    apply(7'b1111111, 3'd5, 7'b0100000, 32'd7, 32'd9, "R1 unlisted");
    // R2/R3: every standard register-register code
    for (int f = 0; f < 8; f++) begin
      apply(7'b0110011, 3'(f), 7'b0000000, 32'hF000_00F3, 32'd35, "R3 base");
      apply(7'b0110011, 3'(f), 7'b0100000, 32'hF000_00F3, 32'd35, "R3 alt");
    end
    // R4: funct7=0000001 wins over bit 5 meaning
    for (int f = 0; f < 8; f++) apply(7'b0110011, 3'(f), 7'b0000001, 32'hFFFF_FFF9, 32'd4, "R4");
    // R5: immediate form, funct7 bit 5 ignored at funct3=0
    apply(7'b0010011, 3'd0, 7'b0100000, 32'd10, 32'd3, "R5 no sub");
    apply(7'b0010011, 3'd5, 7'b0100000, 32'h8000_0000, 32'd31, "R5 srai");
    apply(7'b0010011, 3'd5, 7'b0000000, 32'h8000_0000, 32'd31, "R5 srli");
    // R6: shift uses only low five bits; signed vs unsigned compare
    apply(7'b0110011, 3'd1, 7'd0, 32'd1, 32'h0000_0121, "R6 shamt");
    apply(7'b0110011, 3'd2, 7'd0, 32'hFFFF_FFFF, 32'd1, "R6 slt");
    apply(7'b0110011, 3'd3, 7'd0, 32'hFFFF_FFFF, 32'd1, "R6 sltu");
    // R7: high-product corners
    apply(7'b0110011, 3'd1, 7'd1, 32'h8000_0000, 32'h8000_0000, "R7 mulh");
    apply(7'b0110011, 3'd2, 7'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 mulhsu");
    apply(7'b0110011, 3'd3, 7'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 mulhu");
    // R8: truncation toward zero, remainder follows dividend
    apply(7'b0110011, 3'd4, 7'd1, 32'hFFFF_FFF9, 32'd2, "R8 div");
    apply(7'b0110011, 3'd6, 7'd1, 32'hFFFF_FFF9, 32'd2, "R8 rem");
    // R9: zero divisor, including most-negative dividend
    for (int f = 4; f < 8; f++) apply(7'b0110011, 3'(f), 7'd1, 32'h8000_0000, 32'd0, "R9");
    // R10: signed overflow pair
    apply(7'b0110011, 3'd4, 7'd1, 32'h8000_0000, 32'hFFFF_FFFF, "R10 div");
    apply(7'b0110011, 3'd6, 7'd1, 32'h8000_0000, 32'hFFFF_FFFF, "R10 rem");
    apply(7'b0110011, 3'd5, 7'd1, 32'h8000_0000, 32'hFFFF_FFFF, "R10 divu");
    // Constrained random mix across all requirements (R3 R4 R5 R6 R7 R8)
    for (int k = 0; k < 4000; k++) begin
      int sel;
      logic [6:0] f7;
      sel = $urandom % 10;
      f7 = ($urandom % 3 == 0) ? 7'b0000001 : (($urandom % 2) ? 7'b0100000 : 7'($urandom));
      apply((sel < 9) ? opcs[sel] : 7'($urandom), 3'($urandom), f7, pick_op(), pick_op(), "R6-random");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule